// File: doc/BRIEF.md
# Dual Chip-Enable Static RAM Model

This block is a synthesizable, clock-sampled model of an asynchronous byte-wide static RAM. A memory controller under test drives it through its strobe pins. There are two chip selects: one active low and one active high. There is also an active-low output enable and an active-low write enable. On every rising edge of a fast sampling clock, the model decodes these strobes into one of four modes: deselected, output disabled, read and write. It then drives or releases its data output for the next cycle.

A write is the overlap of both chip selects being active with the write enable low. The byte is committed to a parameterised array on the first sample at which any one of the three strobes has dropped out of the overlap. Because the overlap can be ended by any one of the three strobes, write-enable-ended, low-select-ended and high-select-ended writes all behave the same. The address is reduced to the implemented depth. If the address moves while the overlap is held, the model reports a protocol violation on an error pulse and in a saturating counter that the testbench can inspect.

The strobe pins are plain levels sampled every cycle. They have no valid/ready handshake, because a static RAM exerts no back-pressure. The output enable pin marks when the data output carries a byte.

Top module: `sram_dual_ce`

## Requirements
- R1: When `sel_lo_n` is 1 or `sel_hi` is 0 at a clock edge, `rd_en` is 0 after that edge, whatever `oe_n` and `wr_n` are.
- R2: When selected with `wr_n`=1 and `oe_n`=1 at an edge, `rd_en` is 0 after that edge.
- R3: When selected with `wr_n`=1 and `oe_n`=0 at an edge, `rd_en` is 1 after that edge and `rd_data` holds the byte stored at the sampled address.
- R4: When selected with `wr_n`=0 at an edge, `rd_en` is 0 after that edge even if `oe_n` is 0.
- R5: The write overlap is `sel_lo_n`=0, `sel_hi`=1 and `wr_n`=0. The array is updated at the first edge where the overlap is absent after it was present, whichever of the three strobes ended it.
- R6: The stored byte and location are the `wr_data` and `addr` sampled at the last edge at which the overlap was present.
- R7: A read sampled at the same edge where a write commits, at the same location, returns the newly committed byte.
- R8: Only the low log2(DEPTH) bits of `addr` select a location, so addresses that differ by a multiple of DEPTH alias.
- R9: If the overlap is present at two consecutive edges with different full `addr` values, `err_pulse` is 1 for exactly the cycle after the second edge. Otherwise it is 0.
- R10: `err_count` increments by one with each `err_pulse` and saturates at its all-ones value.
- R11: While `rd_en` is 0, `rd_data` is 0.
- R12: During and right after reset, `rd_en`, `err_pulse` and `err_count` are 0, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Byte presented for writing |
| rd_data | output | DATA_W | Byte driven in read mode, else zero |
| rd_en | output | 1 | Data output is driven (1) or released (0) |
| err_pulse | output | 1 | One-cycle protocol violation flag |
| err_count | output | CNT_W | Saturating violation count |

## Verification
The bench goes after writes ended by each of the three strobes in turn. A model that latched only on the write-enable edge would lose the select-ended writes, and those writes would read back stale. It also changes the data in the middle of a write, reads the location in the very cycle the write commits, and reads through an aliased address. A design that latched the first data, lacked forwarding or decoded the full address would then return the wrong byte. Write mode with the output enable low checks that the output stays released. Address moves inside a held write check that the error pulse lasts exactly one cycle and that the counter tracks it.

// File: rtl/sram_dce_pkg.sv
package sram_dce_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_QUIET = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;

  function automatic sram_mode_e decode_mode(input logic sel_lo_n, input logic sel_hi,
                                             input logic oe_n, input logic wr_n);
    if (sel_lo_n || !sel_hi) return MODE_DESEL;
    if (!wr_n)               return MODE_WRITE;
    if (oe_n)                return MODE_QUIET;
    return MODE_READ;
  endfunction

endpackage

// File: rtl/sram_dce_decode.sv
module sram_dce_decode
  import sram_dce_pkg::*;
(
  input  logic       sel_lo_n,
  input  logic       sel_hi,
  input  logic       oe_n,
  input  logic       wr_n,
  output sram_mode_e mode,
  output logic       wr_overlap,
  output logic       rd_req
);
  always_comb begin
    mode       = decode_mode(sel_lo_n, sel_hi, oe_n, wr_n);
    wr_overlap = (mode == MODE_WRITE);
    rd_req     = (mode == MODE_READ);
  end
endmodule

// File: rtl/sram_dce_wtrack.sv
module sram_dce_wtrack #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_overlap,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic active_q;
  logic viol;

  always_comb begin
    commit = active_q && !wr_overlap;
    viol   = active_q && wr_overlap && (addr != hold_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      err_pulse <= 1'b0;
      err_count <= '0;
    end else begin
      active_q  <= wr_overlap;
      if (wr_overlap) begin
        hold_addr <= addr;
        hold_data <= wr_data;
      end
      err_pulse <= viol;
      if (viol && err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end
  end
endmodule

// File: rtl/sram_dce_array.sv
module sram_dce_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (commit && (wr_idx == rd_idx)) rd_next = wr_byte;
    else                              rd_next = cells[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (commit) cells[wr_idx] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_en   <= rd_req;
      rd_data <= rd_req ? rd_next : '0;
    end
  end
endmodule

// File: rtl/sram_dual_ce.sv
module sram_dual_ce
  import sram_dce_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  sram_mode_e        mode;
  logic              wr_overlap;
  logic              rd_req;
  logic              commit;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  sram_dce_decode u_decode (
    .sel_lo_n   (sel_lo_n),
    .sel_hi     (sel_hi),
    .oe_n       (oe_n),
    .wr_n       (wr_n),
    .mode       (mode),
    .wr_overlap (wr_overlap),
    .rd_req     (rd_req)
  );

  sram_dce_wtrack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_wtrack (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_overlap (wr_overlap),
    .addr       (addr),
    .wr_data    (wr_data),
    .commit     (commit),
    .hold_addr  (hold_addr),
    .hold_data  (hold_data),
    .err_pulse  (err_pulse),
    .err_count  (err_count)
  );

  sram_dce_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .wr_idx  (hold_addr[IDX_W-1:0]),
    .wr_byte (hold_data),
    .rd_req  (rd_req),
    .rd_idx  (addr[IDX_W-1:0]),
    .rd_data (rd_data),
    .rd_en   (rd_en)
  );
endmodule

// File: rtl/sram_dual_ce_chk.sv
module sram_dual_ce_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              sel_lo_n,
  input logic              sel_hi,
  input logic              oe_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_en,
  input logic              err_pulse,
  input logic [CNT_W-1:0]  err_count
);
  logic seen;
  logic sel;
  logic wr_ov;

  always_comb begin
    sel   = !sel_lo_n && sel_hi;
    wr_ov = sel && !wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rd_en);
  // R2
  quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && oe_n) |=> !rd_en);
  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && !oe_n) |=> rd_en);
  // R4
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ov |=> !rd_en);
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
  // R9
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && wr_ov && $past(wr_ov) && (addr != $past(addr))) |=> err_pulse);
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !err_pulse) |-> $stable(err_count));
  // R10
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_count != '0));
endmodule

bind sram_dual_ce sram_dual_ce_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .sel_lo_n  (sel_lo_n),
  .sel_hi    (sel_hi),
  .oe_n      (oe_n),
  .wr_n      (wr_n),
  .rd_data   (rd_data),
  .rd_en     (rd_en),
  .err_pulse (err_pulse),
  .err_count (err_count)
);

// File: tb/sram_dual_ce_bench.sv
module sram_dual_ce_bench;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 256;
  localparam int CNT_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              sel_lo_n = 1'b1;
  logic              sel_hi = 1'b0;
  logic              oe_n = 1'b1;
  logic              wr_n = 1'b1;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_en;
  logic              err_pulse;
  logic [CNT_W-1:0]  err_count;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // expected-state model
  logic [DATA_W-1:0] sh_mem [DEPTH];
  bit                sh_vld [DEPTH];
  bit                e_act = 1'b0;
  logic [ADDR_W-1:0] e_haddr = '0;
  logic [DATA_W-1:0] e_hdata = '0;
  int                e_cnt = 0;
  bit                x_en;
  bit                x_chk_data;
  logic [DATA_W-1:0] x_data;
  bit                x_err;

  always #10 clk = ~clk;

  sram_dual_ce #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_sram_dual_ce (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .oe_n(oe_n), .wr_n(wr_n), .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en),
    .err_pulse(err_pulse), .err_count(err_count)
  );

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'(a % DEPTH);
  endfunction

  // Predict outputs after the coming edge and advance the model.
  function automatic void predict();
    bit sel = !sel_lo_n && sel_hi;
    bit wr  = sel && !wr_n;
    bit rd  = sel && wr_n && !oe_n;
    bit cm  = e_act && !wr;
    int ri  = idx_of(addr);
    x_en = rd;
    x_err = wr && e_act && (addr != e_haddr);
    if (!rd) begin x_chk_data = 1'b1; x_data = '0; end
    else if (cm && idx_of(e_haddr) == ri) begin x_chk_data = 1'b1; x_data = e_hdata; end
    else begin x_chk_data = sh_vld[ri]; x_data = sh_mem[ri]; end
    if (cm) begin sh_mem[idx_of(e_haddr)] = e_hdata; sh_vld[idx_of(e_haddr)] = 1'b1; end
    if (x_err && e_cnt < CMAX) e_cnt++;
    e_act = wr;
    if (wr) begin e_haddr = addr; e_hdata = wr_data; end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input string req, input bit s_lo_n, input bit s_hi, input bit o_n,
                       input bit w_n, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    sel_lo_n = s_lo_n; sel_hi = s_hi; oe_n = o_n; wr_n = w_n; addr = a; wr_data = d;
    predict();
    @(posedge clk);
    #1;
    check({req, " rd_en"}, 32'(rd_en), 32'(x_en));
    if (x_chk_data) check({req, " rd_data"}, 32'(rd_data), 32'(x_data));
    check({req, " err_pulse"}, 32'(err_pulse), 32'(x_err));
    check({req, " err_count"}, 32'(err_count), 32'(e_cnt));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin sh_vld[i] = 1'b0; sh_mem[i] = '0; end
    // R12 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R12 rd_en", 32'(rd_en), 0);
    check("R12 err_pulse", 32'(err_pulse), 0);
    check("R12 err_count", 32'(err_count), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5 write ended by wr_n, R3 read back
    apply("R5 we-wr", 0, 1, 1, 0, 19'd5, 8'hA5);
    apply("R5 we-wr", 0, 1, 1, 0, 19'd5, 8'hA5);
    apply("R2 quiet", 0, 1, 1, 1, 19'd5, 8'h00);
    apply("R3 read", 0, 1, 0, 1, 19'd5, 8'h00);
    // R5 write ended by sel_hi
    apply("R5 hi-wr", 0, 1, 1, 0, 19'd9, 8'h3C);
    apply("R5 hi-wr", 0, 0, 1, 0, 19'd9, 8'h00);
    apply("R5 hi-rd", 0, 1, 0, 1, 19'd9, 8'h00);
    // R5 write ended by sel_lo_n
    apply("R5 lo-wr", 0, 1, 1, 0, 19'd12, 8'h77);
    apply("R1 lo-end", 1, 1, 0, 0, 19'd12, 8'h00);
    apply("R5 lo-rd", 0, 1, 0, 1, 19'd12, 8'h00);
    // R6 data changes mid-write, last sampled byte wins; R4 oe_n low ignored
    apply("R4 oe-low-wr", 0, 1, 0, 0, 19'd20, 8'h11);
    apply("R6 mid-wr", 0, 1, 0, 0, 19'd20, 8'h22);
    // R7 commit and read same location at the same edge
    apply("R7 fwd", 0, 1, 0, 1, 19'd20, 8'h00);
    // R8 aliasing
    apply("R8 alias", 0, 1, 0, 1, 19'(20 + DEPTH), 8'h00);
    // R9/R10 address moves inside a held write
    apply("R9 hold", 0, 1, 1, 0, 19'd30, 8'h44);
    apply("R9 move", 0, 1, 1, 0, 19'd31, 8'h55);
    apply("R9 clear", 0, 1, 1, 1, 19'd31, 8'h00);
    apply("R6 dest", 0, 1, 0, 1, 19'd31, 8'h00);
    // R1 deselected with read strobes
    apply("R1 desel", 1, 0, 0, 1, 19'd31, 8'h00);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] a = addr;
      if ($urandom_range(0, 99) < 20) a = 19'($urandom_range(0, 2 * DEPTH - 1));
      apply("R10 rand",
            ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) != 0),
            ($urandom_range(0, 1) == 1), ($urandom_range(0, 2) != 0),
            a, 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule